// File: doc/BRIEF.md
# Adaptive Update/Invalidate Snooping Cache Controller

This block is the cache side of a snooping coherence scheme for a small multicore. It holds a direct-mapped array of one-word lines. Each line is in one of three states: invalid, read-clean or write-dirty. A processor port issues reads and writes. Every local write is put on the shared bus together with its value. Misses fetch the word from memory. Replacing a dirty line first writes the old word back.

The controller also watches a snoop input that carries the writes of other caches. Each line starts in update mode: a matching remote write overwrites the local copy. Each absorbed update adds a configurable cost to a saturating per-line counter. Once that counter has reached the configurable cost of one invalidation, the next matching remote write drops the line instead. A later local access then takes one miss. Any local hit on a line resets its counter, and so does a refill, because the processor has shown that it still uses the word.

Bus arbitration and the memory are outside the block. A bus operation is assumed to be granted in the cycle it is driven. Memory answers a fetch through a data-valid input.

Top module: `snoop_adapt_ctrl`

## Requirements
- R1: After reset every line is invalid, `bus_req` and `cpu_ack` are low and `cpu_ready` is high.
- R2: A read miss to a clean or invalid slot drives one fetch cycle (`bus_op` = 1, address of the request, data 0). It then waits for `mem_valid`, installs the word read-clean, and pulses `cpu_ack` in the cycle after `mem_valid` with `cpu_rdata` equal to `mem_data`.
- R3: A read hit pulses `cpu_ack` one cycle after acceptance with the stored word and makes no bus request.
- R4: A write hit stores the value, marks the line write-dirty, and drives one broadcast cycle (`bus_op` = 2, address and value) in the cycle after acceptance. `cpu_ack` follows one cycle later with the written value.
- R5: A write miss first broadcasts (`bus_op` = 2), then fetches (`bus_op` = 1). After `mem_valid` it installs the written value, not the memory word, as write-dirty and acknowledges with the written value.
- R6: When a miss maps onto a valid write-dirty line of another address, the first bus cycle is a write-back (`bus_op` = 3) carrying the old line's address and word. The broadcast or fetch follows in the next cycle.
- R7: A snooped remote write (`snp_op` = 2) that matches a valid line whose counter is below the invalidation cost overwrites the word. It leaves the line read-clean, so a later replacement does no write-back.
- R8: Each absorbed update adds UPD_COST to the line's counter, saturating at INV_COST. A matching remote write that arrives while the counter is at INV_COST invalidates the line, and the next local read misses.
- R9: A local read hit, a local write hit or a refill resets the line's counter to zero.
- R10: Snoops with an operation other than 2, snoops whose tag differs from the stored one, and snoops to invalid slots leave the stored data unchanged.
- R11: `cpu_req` is taken only while `cpu_ready` is high. `cpu_ready` is low from acceptance of a miss until its acknowledge, and `cpu_ack` only pulses while `cpu_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write value |
| cpu_ready | output | 1 | Controller idle, request may be presented |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read word, or written value on a write |
| bus_req | output | 1 | A bus operation is driven this cycle |
| bus_op | output | 2 | 0 none, 1 fetch, 2 write broadcast, 3 write-back |
| bus_addr | output | AW | Bus operation address |
| bus_data | output | DW | Broadcast or write-back value |
| mem_valid | input | 1 | Fetched word present on mem_data |
| mem_data | input | DW | Fetched word |
| snp_valid | input | 1 | Snooped bus operation valid |
| snp_op | input | 2 | Snooped operation, same encoding as bus_op |
| snp_addr | input | AW | Snooped address |
| snp_data | input | DW | Snooped value |

## Verification
Several orderings are checked by assertions on every cycle:
- a read hit acknowledges in the next cycle without bus traffic;
- a write hit broadcasts and then acknowledges;
- a fetch is a single bus cycle;
- a write-back is always followed by a broadcast or a fetch;
- an over-threshold remote write clears the slot's valid bit;
- an acknowledge arrives only while idle.

Some behaviours can only be shown by the bench's scenarios. These are the exact counter arithmetic that decides how many updates a line absorbs, the clearing of that counter by hits and refills, the downgrade of a dirty line by a remote update, and the immunity to unrelated snoops. In each case the effect shows up only later, as a hit value or as a miss on the bus.

// File: rtl/snoop_adapt_ctrl.sv
module snoop_adapt_ctrl #(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int LINES    = 8,
  parameter int UPD_COST = 1,
  parameter int INV_COST = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic          cpu_ack,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  output logic [1:0]    bus_op,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_data,
  input  logic          snp_valid,
  input  logic [1:0]    snp_op,
  input  logic [AW-1:0] snp_addr,
  input  logic [DW-1:0] snp_data
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;
  localparam int CW = $clog2(INV_COST + 1);
  localparam logic [CW-1:0] UPD_C = CW'(UPD_COST);
  localparam logic [CW-1:0] INV_C = CW'(INV_COST);
  localparam logic [1:0] OP_NONE = 2'd0;
  localparam logic [1:0] OP_RD   = 2'd1;
  localparam logic [1:0] OP_WR   = 2'd2;
  localparam logic [1:0] OP_WB   = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_WB, S_BCAST, S_FETCH, S_WAIT} st_t;

  st_t             st_q;
  logic            rq_we, rq_hit;
  logic [AW-1:0]   rq_addr;
  logic [DW-1:0]   rq_data;
  logic            ack_q;
  logic [DW-1:0]   rdata_q;

  logic [TW-1:0]   tag_q [LINES];
  logic [DW-1:0]   dat_q [LINES];
  logic [CW-1:0]   cnt_q [LINES];
  logic [LINES-1:0] vld_q, drt_q;

  wire [IW-1:0] c_idx = cpu_addr[IW-1:0];
  wire [TW-1:0] c_tag = cpu_addr[AW-1:IW];
  wire [IW-1:0] r_idx = rq_addr[IW-1:0];
  wire [IW-1:0] s_idx = snp_addr[IW-1:0];
  wire [TW-1:0] s_tag = snp_addr[AW-1:IW];

  wire lkp_hit   = vld_q[c_idx] && (tag_q[c_idx] == c_tag);
  wire vic_dirty = vld_q[c_idx] && drt_q[c_idx];
  wire take      = cpu_ready && cpu_req;

  wire snp_match = snp_valid && (snp_op == OP_WR) && vld_q[s_idx] && (tag_q[s_idx] == s_tag);
  wire snp_kill  = snp_match && (cnt_q[s_idx] >= INV_C);
  wire snp_upd   = snp_match && !snp_kill;

  wire [CW:0]   cnt_sum = {1'b0, cnt_q[s_idx]} + {1'b0, UPD_C};
  wire [CW-1:0] cnt_nxt = (cnt_sum >= {1'b0, INV_C}) ? INV_C : cnt_sum[CW-1:0];

  assign cpu_ready = (st_q == S_IDLE);
  assign cpu_ack   = ack_q;
  assign cpu_rdata = rdata_q;
  assign bus_req   = (bus_op != OP_NONE);

  always_comb begin
    bus_op   = OP_NONE;
    bus_addr = rq_addr;
    bus_data = '0;
    case (st_q)
      S_WB: begin
        bus_op   = OP_WB;
        bus_addr = {tag_q[r_idx], r_idx};
        bus_data = dat_q[r_idx];
      end
      S_BCAST: begin
        bus_op   = OP_WR;
        bus_data = rq_data;
      end
      S_FETCH: bus_op = OP_RD;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      rq_we   <= 1'b0;
      rq_hit  <= 1'b0;
      rq_addr <= '0;
      rq_data <= '0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= 1'b0;
      case (st_q)
        S_IDLE: if (cpu_req) begin
          rq_we   <= cpu_we;
          rq_addr <= cpu_addr;
          rq_data <= cpu_wdata;
          rq_hit  <= lkp_hit;
          if (lkp_hit && !cpu_we) begin
            ack_q   <= 1'b1;
            rdata_q <= dat_q[c_idx];
          end else if (lkp_hit) st_q <= S_BCAST;
          else if (vic_dirty)   st_q <= S_WB;
          else                  st_q <= cpu_we ? S_BCAST : S_FETCH;
        end
        S_WB:    st_q <= rq_we ? S_BCAST : S_FETCH;
        S_BCAST: if (rq_hit) begin
          ack_q   <= 1'b1;
          rdata_q <= rq_data;
          st_q    <= S_IDLE;
        end else st_q <= S_FETCH;
        S_FETCH: st_q <= S_WAIT;
        S_WAIT:  if (mem_valid) begin
          ack_q   <= 1'b1;
          rdata_q <= rq_we ? rq_data : mem_data;
          st_q    <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      drt_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        dat_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      if (snp_upd) begin
        dat_q[s_idx] <= snp_data;
        drt_q[s_idx] <= 1'b0;
        cnt_q[s_idx] <= cnt_nxt;
      end
      if (snp_kill) begin
        vld_q[s_idx] <= 1'b0;
        drt_q[s_idx] <= 1'b0;
      end
      if (take && lkp_hit) begin
        cnt_q[c_idx] <= '0;
        if (cpu_we) begin
          dat_q[c_idx] <= cpu_wdata;
          drt_q[c_idx] <= 1'b1;
        end
      end
      if (st_q == S_WB) vld_q[r_idx] <= 1'b0;
      if (st_q == S_WAIT && mem_valid) begin
        vld_q[r_idx] <= 1'b1;
        tag_q[r_idx] <= rq_addr[AW-1:IW];
        dat_q[r_idx] <= rq_we ? rq_data : mem_data;
        drt_q[r_idx] <= rq_we;
        cnt_q[r_idx] <= '0;
      end
    end
  end
endmodule

// File: rtl/snoop_adapt_chk.sv
module snoop_adapt_chk #(
  parameter int IW    = 3,
  parameter int LINES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req,
  input logic             cpu_we,
  input logic             cpu_ready,
  input logic             cpu_ack,
  input logic             bus_req,
  input logic [1:0]       bus_op,
  input logic             mem_valid,
  input logic             lkp_hit,
  input logic             snp_kill,
  input logic [IW-1:0]    snp_idx,
  input logic [LINES-1:0] vld
);
  // R3
  rd_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_req && !cpu_we && lkp_hit) |=> (cpu_ack && !bus_req));
  // R4
  wr_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_req && cpu_we && lkp_hit) |=> (bus_op == 2'd2) ##1 cpu_ack);
  // R2
  fetch_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op == 2'd1) |=> (!bus_req && !cpu_ready));
  // R6
  wb_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op == 2'd3) |=> (bus_op == 2'd2 || bus_op == 2'd1));
  // R8
  kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_kill && !mem_valid && !(cpu_ready && cpu_req)) |=> !vld[$past(snp_idx)]);
  // R11
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> cpu_ready);
endmodule

bind snoop_adapt_ctrl snoop_adapt_chk #(.IW(IW), .LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_ready(cpu_ready), .cpu_ack(cpu_ack), .bus_req(bus_req), .bus_op(bus_op),
  .mem_valid(mem_valid), .lkp_hit(lkp_hit), .snp_kill(snp_kill),
  .snp_idx(s_idx), .vld(vld_q)
);

// File: tb/tb_snoop_adapt_ctrl.sv
module tb_snoop_adapt_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready, cpu_ack, bus_req;
  logic [DW-1:0] cpu_rdata, bus_data;
  logic [1:0] bus_op;
  logic [AW-1:0] bus_addr;
  logic mem_valid = 0;
  logic [DW-1:0] mem_data = '0;
  logic snp_valid = 0;
  logic [1:0] snp_op = '0;
  logic [AW-1:0] snp_addr = '0;
  logic [DW-1:0] snp_data = '0;

  int n_chk = 0, n_fail = 0, ack_cnt = 0;
  logic [1:0]    q_kind [$];
  logic [1:0]    q_op   [$];
  logic [AW-1:0] q_addr [$];
  logic [DW-1:0] q_data [$];
  string         q_tag  [$];

  snoop_adapt_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] memfn(input logic [AW-1:0] a);
    return {8'hA5, a};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exp_bus(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    q_kind.push_back(2'd0); q_op.push_back(op); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(tag);
  endtask

  task automatic exp_ack(input logic [DW-1:0] d, input string tag);
    q_kind.push_back(2'd1); q_op.push_back(2'd0); q_addr.push_back('0); q_data.push_back(d); q_tag.push_back(tag);
  endtask

  task automatic score(input logic [1:0] kind, input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (q_kind.size() == 0) begin
      n_chk++; n_fail++;
      $display("FAIL unexpected event kind=%0d op=%0d addr=%h data=%h expected none", kind, op, a, d);
    end else begin
      logic [1:0] ek = q_kind.pop_front();
      logic [1:0] eo = q_op.pop_front();
      logic [AW-1:0] ea = q_addr.pop_front();
      logic [DW-1:0] ed = q_data.pop_front();
      string t = q_tag.pop_front();
      check(t, {kind, op, a, d}, {ek, eo, ea, ed});
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (bus_req) score(2'd0, bus_op, bus_addr, bus_data);
    if (cpu_ack) begin ack_cnt++; score(2'd1, 2'd0, '0, cpu_rdata); end
  end

  logic rd_seen = 0;
  logic [AW-1:0] rd_addr = '0;
  always @(negedge clk) begin
    mem_valid = 0;
    if (rd_seen) begin mem_valid = 1; mem_data = memfn(rd_addr); rd_seen = 0; end
    if (rst_n && bus_op == 2'd1) begin rd_seen = 1; rd_addr = bus_addr; end
  end

  task automatic cpu(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit chk_busy);
    int prev = ack_cnt;
    int guard = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 0;
    #1;
    if (chk_busy) check("R11 ready low during miss", {31'd0, cpu_ready}, 32'd0);
    while (ack_cnt == prev && guard < 200) begin @(negedge clk); #1; guard++; end
    if (ack_cnt == prev) begin n_chk++; n_fail++; $display("FAIL R11 no ack actual=none expected=ack"); end
  endtask

  task automatic snoop(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    snp_valid = 1; snp_op = op; snp_addr = a; snp_data = d;
    @(negedge clk);
    snp_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 bus_req", {31'd0, bus_req}, 0);
    check("R1 cpu_ack", {31'd0, cpu_ack}, 0);
    check("R1 cpu_ready", {31'd0, cpu_ready}, 1);

    exp_bus(2'd1, 8'h11, 16'h0, "R1 R2 fetch on cold read");
    exp_ack(memfn(8'h11), "R2 read miss data");
    cpu(0, 8'h11, 0, 1);
    exp_ack(memfn(8'h11), "R3 read hit");
    cpu(0, 8'h11, 0, 0);
    exp_bus(2'd2, 8'h11, 16'h1234, "R4 write hit broadcast");
    exp_ack(16'h1234, "R4 write hit ack");
    cpu(1, 8'h11, 16'h1234, 0);

    exp_bus(2'd2, 8'h22, 16'hBEEF, "R5 write miss broadcast");
    exp_bus(2'd1, 8'h22, 16'h0, "R5 write miss fetch");
    exp_ack(16'hBEEF, "R5 write miss ack");
    cpu(1, 8'h22, 16'hBEEF, 1);
    exp_ack(16'hBEEF, "R5 line holds written value");
    cpu(0, 8'h22, 0, 0);

    exp_bus(2'd3, 8'h22, 16'hBEEF, "R6 write-back victim 22");
    exp_bus(2'd1, 8'h1A, 16'h0, "R6 fetch after write-back");
    exp_ack(memfn(8'h1A), "R6 read data");
    cpu(0, 8'h1A, 0, 1);
    exp_bus(2'd3, 8'h11, 16'h1234, "R6 write-back victim 11");
    exp_bus(2'd1, 8'h19, 16'h0, "R6 fetch 19");
    exp_ack(memfn(8'h19), "R6 read data 19");
    cpu(0, 8'h19, 0, 1);

    snoop(2'd2, 8'h19, 16'h0101);
    exp_ack(16'h0101, "R7 update absorbed");
    cpu(0, 8'h19, 0, 0);

    snoop(2'd2, 8'h19, 16'h0A0A);
    snoop(2'd2, 8'h19, 16'h0B0B);
    snoop(2'd2, 8'h19, 16'h0C0C);
    exp_ack(16'h0C0C, "R8 updates up to threshold absorbed");
    cpu(0, 8'h19, 0, 0);
    snoop(2'd2, 8'h19, 16'h0D01);
    snoop(2'd2, 8'h19, 16'h0D02);
    snoop(2'd2, 8'h19, 16'h0D03);
    snoop(2'd2, 8'h19, 16'h0D04);
    exp_bus(2'd1, 8'h19, 16'h0, "R8 invalidated line misses");
    exp_ack(memfn(8'h19), "R8 refill data");
    cpu(0, 8'h19, 0, 1);

    snoop(2'd2, 8'h19, 16'h0E01);
    snoop(2'd2, 8'h19, 16'h0E02);
    snoop(2'd2, 8'h19, 16'h0E03);
    exp_ack(16'h0E03, "R9 refill cleared counter");
    cpu(0, 8'h19, 0, 0);

    snoop(2'd2, 8'h19, 16'h0F01);
    snoop(2'd2, 8'h19, 16'h0F02);
    exp_bus(2'd2, 8'h19, 16'h7777, "R9 write hit broadcast");
    exp_ack(16'h7777, "R9 write hit ack");
    cpu(1, 8'h19, 16'h7777, 0);
    snoop(2'd2, 8'h19, 16'h0F03);
    snoop(2'd2, 8'h19, 16'h0F04);
    snoop(2'd2, 8'h19, 16'h0F05);
    exp_ack(16'h0F05, "R9 write hit cleared counter");
    cpu(0, 8'h19, 0, 0);

    exp_bus(2'd2, 8'h19, 16'h8888, "R7 write hit makes dirty");
    exp_ack(16'h8888, "R7 write ack");
    cpu(1, 8'h19, 16'h8888, 0);
    snoop(2'd2, 8'h19, 16'h9999);
    exp_bus(2'd1, 8'h11, 16'h0, "R7 updated line is clean, no write-back");
    exp_ack(memfn(8'h11), "R7 read data 11");
    cpu(0, 8'h11, 0, 1);

    snoop(2'd1, 8'h11, 16'h5555);
    snoop(2'd3, 8'h11, 16'h6666);
    snoop(2'd2, 8'h29, 16'h7777);
    snoop(2'd2, 8'h23, 16'h4444);
    exp_ack(memfn(8'h11), "R10 ignored snoops keep data");
    cpu(0, 8'h11, 0, 0);
    exp_bus(2'd1, 8'h23, 16'h0, "R10 snoop did not fill invalid slot");
    exp_ack(memfn(8'h23), "R10 read data 23");
    cpu(0, 8'h23, 0, 1);

    repeat (3) @(negedge clk);
    check("R11 all expected events seen", q_kind.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule